// File: doc/BRIEF.md
# AUX channel request preamble generator

This block drives the opening of a Manchester-II coded request on a two-wire auxiliary channel. A one-cycle `start` strobe begins the preamble. The block first sends a run of Manchester zero symbols, which covers both the line pre-charge and the sync run. It then sends the end-of-sync marker, and finally pulses `done` so that a downstream data serializer can take over the line. While the preamble is on the wire, `line_oe` enables the differential driver.

The length of the zero run is a fixed base of 26 symbols plus an extension. The extension is set by a programmable field counted in 2 µs steps, and each step adds two zero symbols. The protocol limits the whole zero run to 32 symbols. If the field asks for more, the block sends exactly 32 and raises `cfg_err`. All timing comes from `half_tick`, an external strobe that occurs twice per 1 µs bit period. A plain start pulse is the only handshake, and no streamed data passes through the block.

Top module: `aux_preamble_gen`

## Requirements
- R1: After reset, `line_oe`, `line_out` and `done` are all 0, and they stay 0 until a `start` is accepted.
- R2: A `start` sampled while idle raises `line_oe` in the next cycle. The line then begins the first half of the first zero symbol at level 0.
- R3: Each zero symbol is two halves, low and then high, which gives a low-to-high transition mid-bit. A half ends only on the clock edge that samples `half_tick`=1. Between ticks the line holds its level.
- R4: When 26 + 2·`extra_pc` is no more than 32, exactly that many zero symbols are sent.
- R5: When 26 + 2·`extra_pc` exceeds 32 (`extra_pc` > 3), exactly 32 zero symbols are sent. In that case `cfg_err` is 1, and at all other times it is 0. `cfg_err` follows `extra_pc` combinationally.
- R6: After the last zero symbol the end marker follows. It is four half periods high, then four half periods low, with no mid-bit transitions.
- R7: The cycle after the tick that ends the eighth marker half, `done` is 1 for exactly one cycle. `line_oe` is 0 in that same cycle.
- R8: A `start` that arrives while a preamble is in progress has no effect on the symbol sequence or on its length.
- R9: `extra_pc` is captured when `start` is accepted. Later changes do not alter the preamble in progress.
- R10: `line_out` is 0 whenever `line_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_tick | input | 1 | One-cycle strobe marking each half-bit boundary |
| start | input | 1 | One-cycle request to begin a preamble |
| extra_pc | input | FW | Extra pre-charge in 2 µs steps (2 symbols per step) |
| line_out | output | 1 | Serial line level |
| line_oe | output | 1 | Driver enable |
| done | output | 1 | One-cycle hand-off strobe to the serializer |
| cfg_err | output | 1 | Requested zero count exceeds the protocol maximum |

## Verification
The hardest situations to reach are the ones where the block is disturbed mid-frame. One is a `start` strobe landing between half ticks of a frame already running. Another is `extra_pc` changing after the count has been latched. Only a wrong frame length or a wrong symbol, seen several microseconds later, would reveal a fault. The random frames insert random idle gaps between half ticks and, in those gaps and on tick cycles, randomly pulse `start` and rewrite `extra_pc`. Every half period is compared with the sequence expected for the value captured at frame start. Directed frames cover field values 0, 3, 4 and the all-ones field.

// File: rtl/aux_pre_pkg.sv
package aux_pre_pkg;
  localparam int BASE_ZEROS = 26;
  localparam int MAX_ZEROS  = 32;
  localparam int MARK_HALVES = 8;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ZERO = 2'd1,
    PH_MARK = 2'd2
  } phase_t;
endpackage

// File: rtl/aux_pre_budget.sv
module aux_pre_budget #(
  parameter int FW   = 4,
  parameter int BASE = 26,
  parameter int MAX  = 32,
  localparam int CW  = $clog2(BASE + 2 * ((1 << FW) - 1) + 1),
  localparam int ZW  = $clog2(MAX + 1)
) (
  input  logic [FW-1:0] extra,
  output logic [ZW-1:0] zcount,
  output logic          over
);
  logic [CW-1:0] raw;

  always_comb begin
    raw    = CW'(BASE) + CW'({extra, 1'b0});
    over   = raw > CW'(MAX);
    zcount = over ? ZW'(MAX) : ZW'(raw);
  end
endmodule

// File: rtl/aux_pre_seq.sv
module aux_pre_seq
  import aux_pre_pkg::*;
#(
  parameter int MAX    = 32,
  parameter int MARKS  = 8,
  localparam int ZW    = $clog2(MAX + 1),
  localparam int HW    = $clog2(2 * MAX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          tick,
  input  logic [ZW-1:0] zcount,
  output phase_t        phase,
  output logic [HW-1:0] hcnt,
  output logic          done
);
  logic [HW-1:0] lim;
  logic          zero_last;
  logic          mark_last;

  assign zero_last = (hcnt == lim);
  assign mark_last = (hcnt == HW'(MARKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      hcnt  <= '0;
      lim   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (start) begin
            phase <= PH_ZERO;
            hcnt  <= '0;
            lim   <= HW'({zcount, 1'b0} - (ZW + 1)'(1));
          end
        end
        PH_ZERO: begin
          if (tick) begin
            if (zero_last) begin
              phase <= PH_MARK;
              hcnt  <= '0;
            end else begin
              hcnt <= hcnt + HW'(1);
            end
          end
        end
        PH_MARK: begin
          if (tick) begin
            if (mark_last) begin
              phase <= PH_IDLE;
              hcnt  <= '0;
              done  <= 1'b1;
            end else begin
              hcnt <= hcnt + HW'(1);
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/aux_pre_enc.sv
module aux_pre_enc
  import aux_pre_pkg::*;
#(
  parameter int HW    = 6,
  parameter int MARKS = 8
) (
  input  phase_t        phase,
  input  logic [HW-1:0] hcnt,
  output logic          line,
  output logic          oe
);
  localparam int HIGH_HALVES = MARKS / 2;

  always_comb begin
    oe   = (phase != PH_IDLE);
    line = 1'b0;
    unique case (phase)
      PH_ZERO: line = hcnt[0];
      PH_MARK: line = (hcnt < HW'(HIGH_HALVES));
      default: line = 1'b0;
    endcase
  end
endmodule

// File: rtl/aux_preamble_gen.sv
module aux_preamble_gen
  import aux_pre_pkg::*;
#(
  parameter int FW   = 4,
  parameter int BASE = BASE_ZEROS,
  parameter int MAX  = MAX_ZEROS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          half_tick,
  input  logic          start,
  input  logic [FW-1:0] extra_pc,
  output logic          line_out,
  output logic          line_oe,
  output logic          done,
  output logic          cfg_err
);
  localparam int ZW = $clog2(MAX + 1);
  localparam int HW = $clog2(2 * MAX);

  logic [ZW-1:0] zcount;
  phase_t        phase;
  logic [HW-1:0] hcnt;

  aux_pre_budget #(.FW(FW), .BASE(BASE), .MAX(MAX)) budget_i (
    .extra  (extra_pc),
    .zcount (zcount),
    .over   (cfg_err)
  );

  aux_pre_seq #(.MAX(MAX), .MARKS(MARK_HALVES)) seq_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .tick   (half_tick),
    .zcount (zcount),
    .phase  (phase),
    .hcnt   (hcnt),
    .done   (done)
  );

  aux_pre_enc #(.HW(HW), .MARKS(MARK_HALVES)) enc_i (
    .phase (phase),
    .hcnt  (hcnt),
    .line  (line_out),
    .oe    (line_oe)
  );
endmodule

// File: rtl/aux_preamble_gen_chk.sv
module aux_preamble_gen_chk #(
  parameter int FW   = 4,
  parameter int BASE = 26,
  parameter int MAX  = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          half_tick,
  input logic          start,
  input logic [FW-1:0] extra_pc,
  input logic          line_out,
  input logic          line_oe,
  input logic          done,
  input logic          cfg_err
);
  localparam int SAFE_STEPS = (MAX - BASE) / 2;

  // R10
  idle_line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_oe |-> !line_out);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_oe_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !line_oe);

  // R3
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_oe && !half_tick) |=> (line_oe && $stable(line_out)));

  // R2
  oe_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_oe) |-> $past(start));

  // R5
  cfg_err_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err == (int'(extra_pc) > SAFE_STEPS));
endmodule

bind aux_preamble_gen aux_preamble_gen_chk #(.FW(FW), .BASE(BASE), .MAX(MAX)) chk_i (.*);

// File: tb/aux_preamble_gen_tb_top.sv
module aux_preamble_gen_tb_top;
  localparam int FW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          half_tick = 1'b0;
  logic          start = 1'b0;
  logic [FW-1:0] extra_pc = '0;
  logic          line_out, line_oe, done, cfg_err;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  aux_preamble_gen #(.FW(FW)) dut_i (
    .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .start(start),
    .extra_pc(extra_pc), .line_out(line_out), .line_oe(line_oe),
    .done(done), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int zeros_for(input int ex);
    int t = 26 + 2 * ex;
    return (t > 32) ? 32 : t;
  endfunction

  function automatic bit exp_level(input int i, input int n);
    if (i < 2 * n) return i[0];
    return (i - 2 * n) < 4;
  endfunction

  task automatic run_frame(input int ex, input bit rnd);
    int n;
    n = zeros_for(ex);
    @(negedge clk);
    extra_pc = FW'(ex);
    #1;
    chk(cfg_err == (ex > 3), "R5", cfg_err, ex > 3);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(line_oe == 1'b1 && line_out == 1'b0, "R2", {line_oe, line_out}, 2);
    for (int i = 0; i < 2 * n + 8; i++) begin
      int gap;
      bit e;
      string tag;
      gap = rnd ? int'($urandom % 3) : 0;
      e = exp_level(i, n);
      for (int g = 0; g < gap; g++) begin
        bit s;
        s = $urandom % 2;
        chk(line_oe && line_out == e, s ? "R8" : "R3", line_out, e);
        start = s;
        if (rnd) extra_pc = FW'($urandom);
        @(negedge clk);
        start = 1'b0;
      end
      if (i >= 2 * n)      tag = "R6";
      else if (rnd)        tag = "R9";
      else if (ex > 3)     tag = "R5";
      else                 tag = "R4";
      chk(line_oe && line_out == e && !done, tag, line_out, e);
      half_tick = 1'b1;
      start = rnd ? 1'($urandom % 2) : 1'b0;
      @(negedge clk);
      half_tick = 1'b0;
      start = 1'b0;
    end
    chk(done == 1'b1 && line_oe == 1'b0, "R7", {done, line_oe}, 2);
    chk(line_out == 1'b0, "R10", line_out, 0);
    @(negedge clk);
    chk(done == 1'b0 && line_oe == 1'b0, "R7", {done, line_oe}, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(line_oe == 0 && line_out == 0 && done == 0, "R1",
        {line_oe, line_out, done}, 0);
    rst_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      half_tick = 1'b1;
      @(negedge clk);
      half_tick = 1'b0;
      chk(line_oe == 0 && line_out == 0 && done == 0, "R1",
          {line_oe, line_out, done}, 0);
    end
    run_frame(0, 1'b0);
    run_frame(3, 1'b0);
    run_frame(4, 1'b0);
    run_frame(15, 1'b0);
    for (int k = 0; k < 24; k++) run_frame(int'($urandom % 16), 1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule